// File: doc/BRIEF.md
# Sixteen-Bit Arithmetic and Logic Unit with Status Flags

This block is the arithmetic and logic core of a small execution unit. It takes two 16-bit operands, an operation select, a byte or word width select and an 8-bit shift count. It produces a 16-bit result combinationally, in the same cycle. Beside the result it keeps five status flags in a register: carry, zero, sign, overflow and parity. The flags load on the rising clock edge whenever the update enable is high.

Each operation has its own rule for which flags it writes. Increment and decrement leave carry untouched. The logic operations clear carry and overflow. Rotates write only carry and overflow. A shift or rotate with a count of zero changes nothing. In byte mode the unit works on the low eight bits of each operand, and the result's upper byte reads zero. Downstream decode logic is expected to select the operation and to sequence the flag writes.

Top module: `alu16_flags_unit`

## Requirements
- R1: Operation encoding is 0 add, 1 subtract, 2 increment, 3 decrement, 4 AND, 5 OR, 6 XOR, 7 NOT, 8 shift left, 9 shift right, 10 rotate left, 11 rotate right. Add returns the operand sum modulo the active width. Carry is the carry out of the top bit. Overflow is set when both operands share a sign that the result does not.
- R2: Subtract returns a minus b modulo the active width. Carry is set when a borrow occurred (a below b, unsigned). Overflow is set when the operand signs differ and the result sign differs from a's.
- R3: Increment and decrement add or remove one from a and ignore b. They update zero, sign, overflow and parity, and leave carry at its previous value.
- R4: AND, OR, XOR and NOT (NOT inverts a) clear carry and overflow, and update zero, sign and parity.
- R5: For every operation that writes them, zero is set when the result is all zeros. Sign copies the top bit of the active width. Parity is set when the low eight result bits hold an even number of ones.
- R6: With byte_i high, only bits 7:0 of each operand are used and result bits 15:8 are zero. Sign comes from result bit 7 and carry from bit 8 of the sum or difference. With byte_i low, sign comes from bit 15 and carry from bit 16.
- R7: Shift left and shift right move a by cnt_i positions and fill with zeros. Carry is the last bit moved out, and reads 0 once cnt_i exceeds the active width. Overflow is cleared, and zero, sign and parity are updated.
- R8: Rotate left and rotate right turn a by cnt_i modulo the active width. After rotate left, carry equals result bit 0. After rotate right, carry equals the result's top active bit. Overflow is cleared. Zero, sign and parity keep their values.
- R9: For opcodes 8 to 11 with cnt_i equal to 0, the result equals the width-masked a and no flag changes.
- R10: Flags load on the rising clock edge only while upd_i is high. With upd_i low they hold.
- R11: While rst_n is low, all five flags are cleared.
- R12: Opcodes 12 to 15 return a zero result and leave every flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| op_i | input | 4 | Operation select |
| byte_i | input | 1 | 1 = byte width, 0 = word width |
| cnt_i | input | 8 | Shift or rotate count |
| upd_i | input | 1 | Flag update enable |
| res_o | output | 16 | Combinational result |
| cf_o | output | 1 | Carry or borrow flag |
| zf_o | output | 1 | Zero flag |
| sf_o | output | 1 | Sign flag |
| of_o | output | 1 | Overflow flag |
| pf_o | output | 1 | Parity flag (even ones in low byte) |

## Verification
The clocked assertions assume that op_i, upd_i, byte_i and the operands are held steady around each rising edge. They also assume these inputs carry known values from reset onward, because the zero-flag check compares against the result seen one cycle earlier. The bench meets both conditions by changing every input only on the falling edge and by driving all inputs to zero before reset is released. The random stimulus draws opcodes across the full 4-bit range, so the unused codes are exercised. Counts are drawn from both a small range and the full 8-bit range, which reaches the zero-count and beyond-width cases.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_INC = 4'd2,
        OP_DEC = 4'd3,
        OP_AND = 4'd4,
        OP_OR  = 4'd5,
        OP_XOR = 4'd6,
        OP_NOT = 4'd7,
        OP_SHL = 4'd8,
        OP_SHR = 4'd9,
        OP_ROL = 4'd10,
        OP_ROR = 4'd11
    } alu_op_e;

    typedef struct packed {
        logic cf;
        logic zf;
        logic sf;
        logic of;
        logic pf;
    } flags_t;

    localparam int PAR_W = 8;

endpackage

// File: rtl/alu16_arith.sv
module alu16_arith #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic          sub_i,
    input  logic          one_i,
    input  logic          byte_i,
    output logic [DW-1:0] res_o,
    output logic          cf_o,
    output logic          of_o
);
    localparam int HW = DW / 2;

    logic [DW-1:0] rhs;
    logic [DW:0]   full;
    logic          sgn_a, sgn_b, sgn_r;

    always_comb begin
        rhs  = one_i ? DW'(1) : b_i;
        full = sub_i ? ({1'b0, a_i} - {1'b0, rhs}) : ({1'b0, a_i} + {1'b0, rhs});
        if (byte_i) begin
            res_o = {{(DW-HW){1'b0}}, full[HW-1:0]};
            cf_o  = full[HW];
            sgn_a = a_i[HW-1];
            sgn_b = rhs[HW-1];
            sgn_r = full[HW-1];
        end else begin
            res_o = full[DW-1:0];
            cf_o  = full[DW];
            sgn_a = a_i[DW-1];
            sgn_b = rhs[DW-1];
            sgn_r = full[DW-1];
        end
        if (sub_i) of_o = (sgn_a != sgn_b) && (sgn_r != sgn_a);
        else       of_o = (sgn_a == sgn_b) && (sgn_r != sgn_a);
    end

endmodule

// File: rtl/alu16_logic.sv
module alu16_logic #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic [1:0]    sel_i,
    input  logic          byte_i,
    output logic [DW-1:0] res_o
);
    localparam int HW = DW / 2;

    logic [DW-1:0] raw;
    logic [DW-1:0] keep;

    always_comb begin
        unique case (sel_i)
            2'd0:    raw = a_i & b_i;
            2'd1:    raw = a_i | b_i;
            2'd2:    raw = a_i ^ b_i;
            default: raw = ~a_i;
        endcase
        keep  = byte_i ? {{(DW-HW){1'b0}}, {HW{1'b1}}} : {DW{1'b1}};
        res_o = raw & keep;
    end

endmodule

// File: rtl/alu16_shift.sv
module alu16_shift #(
    parameter int DW = 16,
    parameter int CW = 8
) (
    input  logic [DW-1:0] a_i,
    input  logic [CW-1:0] cnt_i,
    input  logic [1:0]    kind_i,
    input  logic          byte_i,
    output logic [DW-1:0] res_o,
    output logic          cf_o
);
    localparam int HW = DW / 2;

    logic [DW:0]   sl, sr;
    logic [CW-1:0] amt;
    logic [HW-1:0] lo, rl_b, rr_b;
    logic [DW-1:0] rl_w, rr_w;

    always_comb begin
        sl   = {1'b0, a_i} << cnt_i;
        sr   = {a_i, 1'b0} >> cnt_i;
        amt  = byte_i ? (cnt_i % CW'(HW)) : (cnt_i % CW'(DW));
        lo   = a_i[HW-1:0];
        rl_w = (a_i << amt) | (a_i >> (DW - int'(amt)));
        rr_w = (a_i >> amt) | (a_i << (DW - int'(amt)));
        rl_b = (lo << amt) | (lo >> (HW - int'(amt)));
        rr_b = (lo >> amt) | (lo << (HW - int'(amt)));
        unique case (kind_i)
            2'd0: begin
                res_o = byte_i ? {{(DW-HW){1'b0}}, sl[HW-1:0]} : sl[DW-1:0];
                cf_o  = byte_i ? sl[HW] : sl[DW];
            end
            2'd1: begin
                res_o = sr[DW:1];
                cf_o  = sr[0];
            end
            2'd2: begin
                res_o = byte_i ? {{(DW-HW){1'b0}}, rl_b} : rl_w;
                cf_o  = res_o[0];
            end
            default: begin
                res_o = byte_i ? {{(DW-HW){1'b0}}, rr_b} : rr_w;
                cf_o  = byte_i ? res_o[HW-1] : res_o[DW-1];
            end
        endcase
    end

    // R9
    always_comb begin
        if (cnt_i == '0) begin
            zero_count_pass_chk: assert (res_o == a_i);
        end
    end

endmodule

// File: rtl/alu16_flags_unit.sv
module alu16_flags_unit
    import alu16_pkg::*;
#(
    parameter int DW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic [3:0]    op_i,
    input  logic          byte_i,
    input  logic [CW-1:0] cnt_i,
    input  logic          upd_i,
    output logic [DW-1:0] res_o,
    output logic          cf_o,
    output logic          zf_o,
    output logic          sf_o,
    output logic          of_o,
    output logic          pf_o
);
    localparam int HW = DW / 2;

    alu_op_e       op;
    logic [DW-1:0] am, bm;
    logic [DW-1:0] ar_res, lg_res, sh_res;
    logic          ar_cf, ar_of, sh_cf;
    flags_t        flg_d, flg_q;
    logic          zsp_z, zsp_s, zsp_p;

    assign op = alu_op_e'(op_i);
    assign am = byte_i ? {{(DW-HW){1'b0}}, a_i[HW-1:0]} : a_i;
    assign bm = byte_i ? {{(DW-HW){1'b0}}, b_i[HW-1:0]} : b_i;

    alu16_arith #(.DW(DW)) u_arith (
        .a_i    (am),
        .b_i    (bm),
        .sub_i  (op_i[0]),
        .one_i  (op_i[1]),
        .byte_i (byte_i),
        .res_o  (ar_res),
        .cf_o   (ar_cf),
        .of_o   (ar_of)
    );

    alu16_logic #(.DW(DW)) u_logic (
        .a_i    (am),
        .b_i    (bm),
        .sel_i  (op_i[1:0]),
        .byte_i (byte_i),
        .res_o  (lg_res)
    );

    alu16_shift #(.DW(DW), .CW(CW)) u_shift (
        .a_i    (am),
        .cnt_i  (cnt_i),
        .kind_i (op_i[1:0]),
        .byte_i (byte_i),
        .res_o  (sh_res),
        .cf_o   (sh_cf)
    );

    always_comb begin
        if (op_i[3:2] == 2'b00)      res_o = ar_res;
        else if (op_i[3:2] == 2'b01) res_o = lg_res;
        else if (op_i[3:2] == 2'b10) res_o = sh_res;
        else                         res_o = '0;

        zsp_z = (res_o == '0);
        zsp_s = byte_i ? res_o[HW-1] : res_o[DW-1];
        zsp_p = ~^res_o[PAR_W-1:0];

        flg_d = flg_q;
        if (upd_i) begin
            unique case (op)
                OP_ADD, OP_SUB: begin
                    flg_d = '{cf: ar_cf, zf: zsp_z, sf: zsp_s, of: ar_of, pf: zsp_p};
                end
                OP_INC, OP_DEC: begin
                    flg_d = '{cf: flg_q.cf, zf: zsp_z, sf: zsp_s, of: ar_of, pf: zsp_p};
                end
                OP_AND, OP_OR, OP_XOR, OP_NOT: begin
                    flg_d = '{cf: 1'b0, zf: zsp_z, sf: zsp_s, of: 1'b0, pf: zsp_p};
                end
                OP_SHL, OP_SHR: begin
                    if (cnt_i != '0)
                        flg_d = '{cf: sh_cf, zf: zsp_z, sf: zsp_s, of: 1'b0, pf: zsp_p};
                end
                OP_ROL, OP_ROR: begin
                    if (cnt_i != '0) begin
                        flg_d.cf = sh_cf;
                        flg_d.of = 1'b0;
                    end
                end
                default: flg_d = flg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flg_q <= '0;
        else        flg_q <= flg_d;
    end

    assign cf_o = flg_q.cf;
    assign zf_o = flg_q.zf;
    assign sf_o = flg_q.sf;
    assign of_o = flg_q.of;
    assign pf_o = flg_q.pf;

    // R10
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_i |=> $stable({cf_o, zf_o, sf_o, of_o, pf_o}));

    // R3
    incdec_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && (op_i == 4'd2 || op_i == 4'd3)) |=> $stable(cf_o));

    // R4
    logic_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && op_i[3:2] == 2'b01) |=> (!cf_o && !of_o));

    // R9
    zero_count_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && op_i[3:2] == 2'b10 && cnt_i == '0) |=> $stable({cf_o, zf_o, sf_o, of_o, pf_o}));

    // R5
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && op_i[3] == 1'b0) |=> (zf_o == ($past(res_o) == '0)));

    // R6
    byte_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_i |-> (res_o[DW-1:HW] == '0));

    // R12
    unused_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && op_i[3:2] == 2'b11) |=> $stable({cf_o, zf_o, sf_o, of_o, pf_o}));

    // R11
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |-> ({cf_o, zf_o, sf_o, of_o, pf_o} == 5'b0));

endmodule

// File: tb/alu16_flags_unit_bench.sv
module alu16_flags_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] a = '0, b = '0;
    logic [3:0]  op = '0;
    logic        bsel = 1'b0;
    logic [7:0]  cnt = '0;
    logic        upd = 1'b0;
    logic [15:0] res;
    logic        cf, zf, sf, of, pf;

    int checks = 0;
    int fails  = 0;
    logic [4:0] mflags = '0;   // model: {c,z,s,o,p}

    always #5 clk = ~clk;

    alu16_flags_unit u_alu16_flags_unit (
        .clk(clk), .rst_n(rst_n), .a_i(a), .b_i(b), .op_i(op), .byte_i(bsel),
        .cnt_i(cnt), .upd_i(upd), .res_o(res), .cf_o(cf), .zf_o(zf),
        .sf_o(sf), .of_o(of), .pf_o(pf)
    );

    function automatic string req_of(input logic [3:0] o, input logic [7:0] c);
        if (o >= 4'd8 && o <= 4'd11 && c == 8'd0) return "R9";
        case (o)
            4'd0: return "R1";
            4'd1: return "R2";
            4'd2, 4'd3: return "R3";
            4'd4, 4'd5, 4'd6, 4'd7: return "R4";
            4'd8, 4'd9: return "R7";
            4'd10, 4'd11: return "R8";
            default: return "R12";
        endcase
    endfunction

    // returns {result, c, z, s, o, p}
    function automatic logic [20:0] model(input logic [3:0] o, input logic [15:0] ia,
            input logic [15:0] ib, input logic bm, input logic [7:0] c, input logic [4:0] fin);
        int w, mask, sb, ua, ub, r;
        logic fc, fz, fs, fo, fp, zsp;
        logic [15:0] rv;
        w = bm ? 8 : 16;
        mask = (1 << w) - 1;
        sb = 1 << (w - 1);
        ua = int'(ia) & mask;
        ub = int'(ib) & mask;
        {fc, fz, fs, fo, fp} = fin;
        zsp = 1'b0;
        r = 0;
        case (o)
            4'd0: begin r = ua + ub; fc = ((r >> w) & 1) != 0; r = r & mask;
                        fo = (((ua ^ r) & (ub ^ r) & sb) != 0); zsp = 1; end
            4'd1: begin r = (ua - ub) & mask; fc = ua < ub;
                        fo = (((ua ^ ub) & (ua ^ r) & sb) != 0); zsp = 1; end
            4'd2: begin r = (ua + 1) & mask; fo = (r == sb); zsp = 1; end
            4'd3: begin r = (ua - 1) & mask; fo = (ua == sb); zsp = 1; end
            4'd4: begin r = ua & ub; fc = 0; fo = 0; zsp = 1; end
            4'd5: begin r = ua | ub; fc = 0; fo = 0; zsp = 1; end
            4'd6: begin r = ua ^ ub; fc = 0; fo = 0; zsp = 1; end
            4'd7: begin r = (~ua) & mask; fc = 0; fo = 0; zsp = 1; end
            4'd8: begin r = ua;
                        if (c != 0) begin
                            for (int i = 0; i < int'(c); i++) begin
                                fc = (r & sb) != 0; r = (r << 1) & mask;
                            end
                            fo = 0; zsp = 1;
                        end
                  end
            4'd9: begin r = ua;
                        if (c != 0) begin
                            for (int i = 0; i < int'(c); i++) begin
                                fc = (r & 1) != 0; r = r >> 1;
                            end
                            fo = 0; zsp = 1;
                        end
                  end
            4'd10: begin r = ua;
                        if (c != 0) begin
                            for (int i = 0; i < (int'(c) % w); i++)
                                r = ((r << 1) | (r >> (w - 1))) & mask;
                            fc = (r & 1) != 0; fo = 0;
                        end
                   end
            4'd11: begin r = ua;
                        if (c != 0) begin
                            for (int i = 0; i < (int'(c) % w); i++)
                                r = ((r >> 1) | ((r & 1) << (w - 1))) & mask;
                            fc = (r & sb) != 0; fo = 0;
                        end
                   end
            default: r = 0;
        endcase
        rv = r[15:0];
        if (zsp) begin
            fz = (rv == 16'd0);
            fs = (r & sb) != 0;
            fp = ~^rv[7:0];
        end
        return {rv, fc, fz, fs, fo, fp};
    endfunction

    task automatic apply(input logic [3:0] o, input logic [15:0] ia, input logic [15:0] ib,
                         input logic bm, input logic [7:0] c, input logic u);
        logic [20:0] exp;
        logic [4:0]  efl;
        string       rq;
        @(negedge clk);
        op = o; a = ia; b = ib; bsel = bm; cnt = c; upd = u;
        exp = model(o, ia, ib, bm, c, mflags);
        rq = req_of(o, c);
        #1;
        checks++;
        if (res !== exp[20:5]) begin
            fails++;
            $display("FAIL %s%s result op=%0d a=%h b=%h byte=%0b cnt=%0d actual=%h expected=%h",
                     rq, bm ? "/R6" : "", o, ia, ib, bm, c, res, exp[20:5]);
        end
        efl = u ? exp[4:0] : mflags;
        @(posedge clk);
        #1;
        checks++;
        if ({cf, zf, sf, of, pf} !== efl) begin
            fails++;
            $display("FAIL %s%s flags{c,z,s,o,p} op=%0d a=%h b=%h byte=%0b cnt=%0d actual=%b expected=%b",
                     u ? rq : "R10", bm ? "/R6" : "", o, ia, ib, bm, c,
                     {cf, zf, sf, of, pf}, efl);
        end
        mflags = efl;
    endtask

    initial begin : watchdog
        #1500000;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'h5A17));
        repeat (3) @(negedge clk);
        // R11: flags cleared during reset
        checks++;
        if ({cf, zf, sf, of, pf} !== 5'b0) begin
            fails++;
            $display("FAIL R11 reset flags actual=%b expected=00000", {cf, zf, sf, of, pf});
        end
        rst_n = 1'b1;

        // directed corner cases
        apply(4'd0, 16'hFFFF, 16'h0001, 1'b0, 8'd0, 1'b1);   // R1 carry, zero
        apply(4'd0, 16'h7FFF, 16'h0001, 1'b0, 8'd0, 1'b1);   // R1 overflow
        apply(4'd1, 16'h0000, 16'h0001, 1'b0, 8'd0, 1'b1);   // R2 borrow
        apply(4'd1, 16'h8000, 16'h0001, 1'b0, 8'd0, 1'b1);   // R2 overflow
        apply(4'd2, 16'hFFFF, 16'h0000, 1'b0, 8'd0, 1'b1);   // R3 carry kept
        apply(4'd3, 16'h8000, 16'h1234, 1'b0, 8'd0, 1'b1);   // R3 overflow
        apply(4'd0, 16'h1280, 16'h3480, 1'b1, 8'd0, 1'b1);   // R6 byte carry bit 8
        apply(4'd4, 16'hF0F0, 16'h0FF0, 1'b0, 8'd0, 1'b1);   // R4
        apply(4'd7, 16'h00FF, 16'h0000, 1'b1, 8'd0, 1'b1);   // R4 NOT byte -> zero
        apply(4'd8, 16'h0001, 16'h0000, 1'b0, 8'd16, 1'b1);  // R7 count equals width
        apply(4'd9, 16'h8000, 16'h0000, 1'b0, 8'd17, 1'b1);  // R7 count beyond width
        apply(4'd8, 16'h0081, 16'h0000, 1'b1, 8'd1, 1'b1);   // R7 byte shift out
        apply(4'd10, 16'h0081, 16'h0000, 1'b1, 8'd8, 1'b1);  // R8 rotate full byte
        apply(4'd11, 16'h0001, 16'h0000, 1'b0, 8'd1, 1'b1);  // R8 ror word
        apply(4'd8, 16'hABCD, 16'h0000, 1'b0, 8'd0, 1'b1);   // R9
        apply(4'd11, 16'hABCD, 16'h0000, 1'b1, 8'd0, 1'b1);  // R9
        apply(4'd13, 16'hFFFF, 16'hFFFF, 1'b0, 8'd3, 1'b1);  // R12
        apply(4'd0, 16'h0000, 16'h0000, 1'b0, 8'd0, 1'b0);   // R10 hold

        for (int k = 0; k < 3000; k++) begin
            logic [3:0] ro;
            logic [7:0] rc;
            ro = 4'($urandom_range(0, 15));
            rc = ($urandom_range(0, 3) == 0) ? 8'($urandom_range(0, 255))
                                             : 8'($urandom_range(0, 18));
            apply(ro, 16'($urandom), 16'($urandom), 1'($urandom_range(0, 1)), rc,
                  ($urandom_range(0, 7) != 0));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule